// File: doc/BRIEF.md
# Receive FIFO with per-byte error tagging

This block is the receive data path between a serial frame receiver and a processor-facing register pair. Each completed frame arrives as a byte with three per-frame flags: framing, parity and break. The byte and its flags are written together into one FIFO entry, so a flag always stays with the byte it belongs to.

When the processor reads the data register, the oldest entry is popped. The byte and its flags come out in the data word. At the same moment, the flags are loaded into the three lower error bits of a status word. An overrun raises its own status bit in the cycle after it happens. An overrun occurs when a frame completes while the FIFO is full, and the incoming byte is then thrown away. A write strobe to the error-clear register clears the status word. Serial sampling and baud timing belong to the receiver in front of this block.

Top module: `rxq_frontend`

## Requirements
- R1: After reset, `stat_word` and `dr_word` are all zero, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Bytes leave the FIFO in arrival order. `fifo_full` rises once DEPTH entries are held, and `fifo_empty` rises once the last entry is popped. Pointers wrap correctly for any DEPTH, including one that is not a power of two.
- R3: The `dr_word` register is loaded one cycle after a `dr_rd` pulse on a non-empty FIFO. Its fields are:
  - bits DATA_W-1:0 hold the byte.
  - bit DATA_W holds the framing flag, bit DATA_W+1 the parity flag and bit DATA_W+2 the break flag, each from the same frame as the byte.
- R4: The same read loads status bit 0 (framing), bit 1 (parity) and bit 2 (break) from the popped entry. These bits replace the earlier values and are not ORed with them.
- R5: A frame with `rx_valid` high while `fifo_full` is 1 sets status bit 3 (overrun) in the next cycle. That byte is dropped, and the stored entries and their order are unchanged.
- R6: An `ecr_wr` pulse clears status bits 3 to 0 in the next cycle.
- R7: When `ecr_wr` and `dr_rd` fall in the same cycle, the status word ends all zero. The entry is still popped into `dr_word`.
- R8: When an overrun and `ecr_wr` fall in the same cycle, status ends with bit 3 set and bits 2 to 0 clear.
- R9: A `dr_rd` pulse on an empty FIFO leaves `dr_word` and `stat_word` unchanged.
- R10: Status bits STAT_W-1 to 4 always read zero.
- R11: Bit DATA_W+3 of `dr_word` holds the overrun status bit as it stood in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame completed this cycle |
| rx_data | input | DATA_W | Received byte |
| rx_frm_err | input | 1 | Frame had no valid stop bit |
| rx_par_err | input | 1 | Frame parity mismatch |
| rx_brk | input | 1 | Frame was a break condition |
| dr_rd | input | 1 | Data register read strobe (pops one entry) |
| ecr_wr | input | 1 | Error-clear register write strobe |
| dr_word | output | DATA_W+4 | Data register: byte, flags, overrun |
| stat_word | output | STAT_W | Receive status register |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds DEPTH entries |

## Verification
The bench builds the block with DATA_W=8, STAT_W=32 and DEPTH=5. A depth that is not a power of two selects the compare-and-reset pointer variant. It also lets the FIFO fill, overflow and wrap after only a few pushes. This brings the overrun-with-clear collision and the clear-with-read collision into reach in a few dozen cycles. The power-of-two pointer variant is only elaborated, with the defaults.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // status bit positions
   localparam int unsigned ST_FRM = 0;
   localparam int unsigned ST_PAR = 1;
   localparam int unsigned ST_BRK = 2;
   localparam int unsigned ST_OVR = 3;
   localparam int unsigned ST_ACTIVE = 4;

   typedef struct packed {
      logic brk;
      logic par;
      logic frm;
   } rx_flags_t;

   localparam int unsigned FLAG_W = $bits(rx_flags_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned W     = 11,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdat,
   input  logic         pop,
   output logic [W-1:0] rdat,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdat    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= wdat;
            wr_ptr      <= wr_nxt;
         end
         if (do_pop) rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
   parameter int unsigned STAT_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  rxq_pkg::rx_flags_t         ld_flags,
   input  logic                       ovr_ev,
   input  logic                       clr,
   output logic [STAT_W-1:0]          stat_word
);
   import rxq_pkg::*;

   logic [ST_ACTIVE-1:0] st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (clr) begin
         st_d = '0;
      end else if (load) begin
         st_d[ST_FRM] = ld_flags.frm;
         st_d[ST_PAR] = ld_flags.par;
         st_d[ST_BRK] = ld_flags.brk;
      end
      if (ovr_ev) st_d[ST_OVR] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   generate
      if (STAT_W > ST_ACTIVE) begin : g_pad
         assign stat_word = {{(STAT_W - ST_ACTIVE){1'b0}}, st_q};
      end else begin : g_nopad
         assign stat_word = st_q;
      end
   endgenerate
endmodule

// File: rtl/rxq_frontend.sv
module rxq_frontend #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned STAT_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_valid,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic                rx_frm_err,
   input  logic                rx_par_err,
   input  logic                rx_brk,
   input  logic                dr_rd,
   input  logic                ecr_wr,
   output logic [DATA_W+3:0]   dr_word,
   output logic [STAT_W-1:0]   stat_word,
   output logic                fifo_empty,
   output logic                fifo_full
);
   import rxq_pkg::*;

   localparam int unsigned ENT_W = DATA_W + FLAG_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_frontend: DEPTH must be at least 2");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("rxq_frontend: DATA_W must be 5..9");
      end
      if (STAT_W < ST_ACTIVE) begin : g_bad_stat
         $error("rxq_frontend: STAT_W too small");
      end
   endgenerate

   rx_flags_t         in_flags, head_flags;
   logic [ENT_W-1:0]  in_ent, head_ent;
   logic              pop_ok, ovr_ev;

   assign in_flags = '{brk: rx_brk, par: rx_par_err, frm: rx_frm_err};
   assign in_ent   = {in_flags, rx_data};
   assign pop_ok   = dr_rd && !fifo_empty;
   assign ovr_ev   = rx_valid && fifo_full;
   assign head_flags = rx_flags_t'(head_ent[ENT_W-1:DATA_W]);

   rxq_store #(.W(ENT_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .wdat  (in_ent),
      .pop   (dr_rd),
      .rdat  (head_ent),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   rxq_status #(.STAT_W(STAT_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (pop_ok),
      .ld_flags  (head_flags),
      .ovr_ev    (ovr_ev),
      .clr       (ecr_wr),
      .stat_word (stat_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      dr_word <= '0;
      else if (pop_ok) dr_word <= {stat_word[ST_OVR], head_ent};
   end
endmodule

// File: rtl/rxq_frontend_chk.sv
module rxq_frontend_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned STAT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              dr_rd,
   input logic              ecr_wr,
   input logic [DATA_W+3:0] dr_word,
   input logic [STAT_W-1:0] stat_word,
   input logic              fifo_empty,
   input logic              fifo_full
);
   // R2
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   // R5
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && fifo_full |=> stat_word[3]);

   // R5
   ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && fifo_full && !dr_rd |=> fifo_full);

   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecr_wr && !(rx_valid && fifo_full) |=> stat_word[3:0] == 4'b0000);

   // R8
   ovr_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecr_wr && rx_valid && fifo_full |=> stat_word[3:0] == 4'b1000);

   // R4
   load_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_rd && !fifo_empty && !ecr_wr |=> stat_word[2:0] == dr_word[DATA_W+2:DATA_W]);

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_rd && fifo_empty && !ecr_wr |=> $stable(stat_word) && $stable(dr_word));

   // R11
   ovr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dr_rd && !fifo_empty |=> dr_word[DATA_W+3] == $past(stat_word[3]));

   // R10
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[STAT_W-1:4] == '0);
endmodule

bind rxq_frontend rxq_frontend_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .dr_rd      (dr_rd),
   .ecr_wr     (ecr_wr),
   .dr_word    (dr_word),
   .stat_word  (stat_word),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/test_rxq_frontend.sv
module test_rxq_frontend;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int DP = 5;
   localparam int SW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_frm_err = 1'b0, rx_par_err = 1'b0, rx_brk = 1'b0;
   logic          dr_rd = 1'b0, ecr_wr = 1'b0;
   logic [DW+3:0] dr_word;
   logic [SW-1:0] stat_word;
   logic          fifo_empty, fifo_full;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model, built from the requirements
   logic [DW+2:0] mq[$];
   logic [DW+3:0] exp_dr = '0;
   logic [3:0]    exp_st = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxq_frontend #(.DATA_W(DW), .DEPTH(DP), .STAT_W(SW)) i_rxq_frontend (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk),
      .dr_rd(dr_rd), .ecr_wr(ecr_wr), .dr_word(dr_word), .stat_word(stat_word),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full)
   );

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, "dr_word", 64'(dr_word), 64'(exp_dr));
      check(tag, "stat_word", 64'(stat_word), {32'b0, 28'b0, exp_st});
      check(tag, "fifo_empty", 64'(fifo_empty), 64'(mq.size() == 0));
      check(tag, "fifo_full", 64'(fifo_full), 64'(mq.size() == DP));
   endtask

   // one clock: drive at negedge, update model, check at the next negedge
   task automatic step(bit rv, logic [DW-1:0] d, bit f, bit p, bit b, bit rd, bit clr, string tag);
      bit was_full, ovr;
      logic [DW+2:0] head;
      rx_valid = rv; rx_data = d; rx_frm_err = f; rx_par_err = p; rx_brk = b;
      dr_rd = rd; ecr_wr = clr;
      @(negedge clk);
      was_full = (mq.size() == DP);
      ovr = rv && was_full;
      head = '0;
      if (rd && mq.size() > 0) begin
         head = mq.pop_front();
         exp_dr = {exp_st[3], head};
         if (!clr) exp_st[2:0] = head[DW+2:DW];
      end
      if (clr) exp_st = '0;
      if (ovr) exp_st[3] = 1'b1;
      if (rv && !was_full) mq.push_back({b, p, f, d});
      rx_valid = 0; dr_rd = 0; ecr_wr = 0;
      check_all(tag);
   endtask

   task automatic t_reset();
      check_all("R1");
      check("R10", "upper status", 64'(stat_word[SW-1:4]), 64'd0);
   endtask

   task automatic t_order_flags();
      step(1, 8'hA5, 1, 0, 0, 0, 0, "R2");
      step(1, 8'h3C, 0, 1, 0, 0, 0, "R2");
      step(1, 8'h00, 0, 0, 1, 0, 0, "R2");
      step(0, 8'h00, 0, 0, 0, 1, 0, "R3");
      check("R3", "framing tag", 64'(dr_word[DW]), 64'd1);
      step(0, 8'h00, 0, 0, 0, 1, 0, "R4");
      check("R4", "parity bit", 64'(stat_word[1:0]), 64'b10);
      step(0, 8'h00, 0, 0, 0, 1, 0, "R4");
      check("R4", "break only", 64'(stat_word[3:0]), 64'b0100);
      check("R11", "ovr tag clear", 64'(dr_word[DW+3]), 64'd0);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < DP; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 0, 0, "R2");
      check("R2", "full", 64'(fifo_full), 64'd1);
      step(1, 8'hEE, 1, 1, 1, 0, 0, "R5");
      check("R5", "ovr bit", 64'(stat_word[3]), 64'd1);
      for (int i = 0; i < DP; i++) begin
         step(0, 8'h00, 0, 0, 0, 1, 0, "R5");
         check("R5", "kept byte", 64'(dr_word[DW-1:0]), 64'(8'h10 + i));
      end
      check("R11", "ovr tag", 64'(dr_word[DW+3]), 64'd1);
      check("R2", "empty", 64'(fifo_empty), 64'd1);
   endtask

   task automatic t_clear();
      step(0, 8'h00, 0, 0, 0, 0, 1, "R6");
      check("R6", "status", 64'(stat_word), 64'd0);
   endtask

   task automatic t_empty_read();
      logic [DW+3:0] prev;
      step(1, 8'h77, 0, 1, 0, 0, 0, "R9");
      step(0, 8'h00, 0, 0, 0, 1, 0, "R9");
      prev = dr_word;
      step(0, 8'h00, 0, 0, 0, 1, 0, "R9");
      check("R9", "dr_word held", 64'(dr_word), 64'(prev));
      check("R9", "status held", 64'(stat_word[3:0]), 64'b0010);
   endtask

   task automatic t_clear_vs_read();
      step(1, 8'h5A, 1, 1, 1, 0, 0, "R7");
      step(0, 8'h00, 0, 0, 0, 1, 1, "R7");
      check("R7", "status", 64'(stat_word[3:0]), 64'd0);
      check("R7", "popped", 64'(dr_word[DW-1:0]), 64'h5A);
   endtask

   task automatic t_ovr_vs_clear();
      step(1, 8'hC1, 0, 1, 0, 0, 0, "R8");
      step(0, 8'h00, 0, 0, 0, 1, 0, "R8");
      for (int i = 0; i < DP; i++) step(1, 8'(8'h80 + i), 0, 0, 0, 0, 0, "R8");
      step(1, 8'hFF, 0, 0, 0, 0, 1, "R8");
      check("R8", "status", 64'(stat_word[3:0]), 64'b1000);
      for (int i = 0; i < DP; i++) begin
         step(0, 8'h00, 0, 0, 0, 1, 0, "R2");
         check("R2", "wrap order", 64'(dr_word[DW-1:0]), 64'(8'h80 + i));
      end
      check("R10", "upper status", 64'(stat_word[SW-1:4]), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_flags();
      t_overrun();
      t_clear();
      t_empty_read();
      t_clear_vs_read();
      t_ovr_vs_clear();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule